// File: doc/BRIEF.md
# Two-Wire Master Controller Register Block

This block is the software-facing register file of a two-wire (I2C-style) master controller. It sits between a simple single-cycle register access port and a separate transfer engine that drives the bus wires. Software sets the clock and configuration fields, loads a target address and up to eight bytes of write data, then writes the command register. That write launches one transfer request toward the engine, provided no transfer is already running.

The engine reports the outcome through one-cycle event pulses. These are a done event, three error events (lost arbitration, no response, data collision) and a bus-busy event. It can also load received bytes into the two data registers. Each event sets a sticky status bit, which software clears by writing ones. An interrupt line is raised while any status bit is set and enabled by its mask bit. The done flag and the error flags are captured side by side, so a handler that unmasks only done takes one interrupt per transfer and still reads every error cause in the same status word.

Read data is combinational from the address. A write takes effect at the rising clock edge on which it is presented.

Top module: `twi_ctrl_regs`

## Requirements
- R1: After reset, both clock registers (byte offsets 0x00 and 0x04) read 0x0000301F, the config register (0x08) reads 0x00003302, and status (0x1C), mask (0x20), busy (0x24) and the irq output are all zero.
- R2: A clock register stores a 4-bit filter in bits 15:12 and a 10-bit divider in bits 9:0. All other bits read zero, so writing 0xFFFFFFFF reads back 0x0000F3FF. The high-speed clock image also appears on the output clk_hs_word.
- R3: The config register keeps bits 15:12, 11:8, 7, 6:4, 1 and 0, and every other bit reads zero. Writing 0xFFFFFFFF reads back 0x0000FFF3.
- R4: The address register (0x10) keeps bits 9:0. Data0 (0x14) and data1 (0x18) keep all 32 bits and drive tx_data as {data1, data0}. A cycle with rx_load high loads data0 from rx_data[31:0] and data1 from rx_data[63:32].
- R5: A write to the command register (0x0C) while busy reads zero gives a cmd_start pulse exactly one cycle long, in the cycle after the write. cmd_word takes the written bits 9:0. Busy then reads 1 until an ev_done pulse.
- R6: A command write while busy reads non-zero gives no cmd_start pulse and leaves cmd_word unchanged. It sets status bit 4 (bus busy).
- R7: Status bit 0 is done, bit 1 lost arbitration, bit 2 no response, bit 3 data collision and bit 4 bus busy. Each bit is set by its event pulse and cleared by writing 1 to it. Writing 0 leaves the bit unchanged.
- R8: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R9: The mask register keeps bits 4:0. irq is high exactly while some status bit and its mask bit are both 1. With only done unmasked, error bits captured with done stay readable in status.
- R10: A read of an offset outside the ten registers, unaligned offsets included, returns zero. A write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Register access valid this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset of the access |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data (combinational) |
| ev_done | input | 1 | Engine pulse: transfer finished |
| ev_lost_arb | input | 1 | Engine pulse: arbitration lost |
| ev_no_resp | input | 1 | Engine pulse: target did not acknowledge |
| ev_collision | input | 1 | Engine pulse: data collision |
| ev_bus_busy | input | 1 | Engine pulse: bus found busy |
| rx_load | input | 1 | Load received bytes into the data registers |
| rx_data | input | 64 | Received bytes, data1 in the upper word |
| cmd_start | output | 1 | One-cycle transfer launch request |
| cmd_word | output | CMD_W | Last accepted command value |
| tgt_addr | output | TADDR_W | Target address for the engine |
| tx_data | output | 64 | Bytes to send, {data1, data0} |
| clk_std_word | output | 32 | Standard/fast clock register image |
| clk_hs_word | output | 32 | High-speed clock register image |
| cfg_word | output | 32 | Config register image |
| irq | output | 1 | Level interrupt |

## Verification
Suppose the launch logic believed itself idle while a transfer ran. A second command write would then show a cmd_start pulse and a new cmd_word in the very next cycle, where status bit 4 should have been set instead. A status bit with the wrong set/clear priority shows on the next status read after the colliding cycle, and through irq in that same cycle when the bit is unmasked. Decode or field-mask faults show on the first read of the affected offset, so the bench reads every register right after reset, after all-ones writes and after writes to unmapped offsets.

// File: rtl/twi_regs_pkg.sv
package twi_regs_pkg;

    localparam logic [31:0] OFF_CLK_STD = 32'h00;
    localparam logic [31:0] OFF_CLK_HS  = 32'h04;
    localparam logic [31:0] OFF_CFG     = 32'h08;
    localparam logic [31:0] OFF_CMD     = 32'h0C;
    localparam logic [31:0] OFF_TADDR   = 32'h10;
    localparam logic [31:0] OFF_DAT0    = 32'h14;
    localparam logic [31:0] OFF_DAT1    = 32'h18;
    localparam logic [31:0] OFF_STS     = 32'h1C;
    localparam logic [31:0] OFF_MSK     = 32'h20;
    localparam logic [31:0] OFF_BUSY    = 32'h24;

    localparam int NUM_EV     = 5;
    localparam int EV_DONE    = 0;
    localparam int EV_ARB     = 1;
    localparam int EV_NORESP  = 2;
    localparam int EV_COLL    = 3;
    localparam int EV_BUSBUSY = 4;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_CLK_STD, SEL_CLK_HS, SEL_CFG, SEL_CMD,
        SEL_TADDR, SEL_DAT0, SEL_DAT1, SEL_STS, SEL_MSK, SEL_BUSY
    } reg_sel_e;

    typedef struct packed {
        logic [3:0] filter;
        logic [9:0] div;
    } clk_cfg_t;

    typedef struct packed {
        logic [3:0] arb_flt;
        logic [3:0] nak_cnt;
        logic       addr10;
        logic [2:0] mcode;
        logic       arb_en;
        logic       hs_en;
    } ctl_cfg_t;

    localparam clk_cfg_t CLK_RST = '{filter: 4'h3, div: 10'h01F};
    localparam ctl_cfg_t CTL_RST = '{arb_flt: 4'h3, nak_cnt: 4'h3, addr10: 1'b0,
                                     mcode: 3'h0, arb_en: 1'b1, hs_en: 1'b0};

    function automatic reg_sel_e decode_sel(input logic [31:0] a);
        case (a)
            OFF_CLK_STD: return SEL_CLK_STD;
            OFF_CLK_HS:  return SEL_CLK_HS;
            OFF_CFG:     return SEL_CFG;
            OFF_CMD:     return SEL_CMD;
            OFF_TADDR:   return SEL_TADDR;
            OFF_DAT0:    return SEL_DAT0;
            OFF_DAT1:    return SEL_DAT1;
            OFF_STS:     return SEL_STS;
            OFF_MSK:     return SEL_MSK;
            OFF_BUSY:    return SEL_BUSY;
            default:     return SEL_NONE;
        endcase
    endfunction

    function automatic logic [31:0] clk_image(input clk_cfg_t c);
        return {16'h0, c.filter, 2'b00, c.div};
    endfunction

    function automatic logic [31:0] ctl_image(input ctl_cfg_t c);
        return {16'h0, c.arb_flt, c.nak_cnt, c.addr10, c.mcode, 2'b00, c.arb_en, c.hs_en};
    endfunction

endpackage

// File: rtl/twi_cfg_bank.sv
module twi_cfg_bank
    import twi_regs_pkg::*;
#(
    parameter int TADDR_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we_std,
    input  logic               we_hs,
    input  logic               we_ctl,
    input  logic               we_tgt,
    input  logic               we_d0,
    input  logic               we_d1,
    input  logic [31:0]        wdata,
    input  logic               rx_load,
    input  logic [63:0]        rx_data,
    output clk_cfg_t           clk_std_q,
    output clk_cfg_t           clk_hs_q,
    output ctl_cfg_t           ctl_q,
    output logic [TADDR_W-1:0] tgt_q,
    output logic [31:0]        dat0_q,
    output logic [31:0]        dat1_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_std_q <= CLK_RST;
            clk_hs_q  <= CLK_RST;
            ctl_q     <= CTL_RST;
            tgt_q     <= '0;
        end else begin
            if (we_std) clk_std_q <= '{filter: wdata[15:12], div: wdata[9:0]};
            if (we_hs)  clk_hs_q  <= '{filter: wdata[15:12], div: wdata[9:0]};
            if (we_ctl) ctl_q <= '{arb_flt: wdata[15:12], nak_cnt: wdata[11:8],
                                   addr10: wdata[7], mcode: wdata[6:4],
                                   arb_en: wdata[1], hs_en: wdata[0]};
            if (we_tgt) tgt_q <= wdata[TADDR_W-1:0];
        end
    end

    // Engine load of received bytes takes priority over a software write.
    always_ff @(posedge clk) begin
        if (rst) begin
            dat0_q <= '0;
            dat1_q <= '0;
        end else if (rx_load) begin
            dat0_q <= rx_data[31:0];
            dat1_q <= rx_data[63:32];
        end else begin
            if (we_d0) dat0_q <= wdata;
            if (we_d1) dat1_q <= wdata;
        end
    end

endmodule

// File: rtl/twi_irq_block.sv
module twi_irq_block #(
    parameter int NEV = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NEV-1:0] ev_set,
    input  logic           sts_wr,
    input  logic           msk_wr,
    input  logic [NEV-1:0] wbits,
    output logic [NEV-1:0] sts_q,
    output logic [NEV-1:0] msk_q,
    output logic           irq
);

    for (genvar i = 0; i < NEV; i++) begin : g_flag
        // Set has priority over a write-one clear landing in the same cycle.
        always_ff @(posedge clk) begin
            if (rst)            sts_q[i] <= 1'b0;
            else if (ev_set[i]) sts_q[i] <= 1'b1;
            else if (sts_wr && wbits[i]) sts_q[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         msk_q <= '0;
        else if (msk_wr) msk_q <= wbits;
    end

    assign irq = |(sts_q & msk_q);

endmodule

// File: rtl/twi_cmd_launch.sv
module twi_cmd_launch #(
    parameter int CMD_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_cmd,
    input  logic [CMD_W-1:0] wdata,
    input  logic             done,
    output logic [CMD_W-1:0] cmd_q,
    output logic             busy_q,
    output logic             start_q,
    output logic             reject
);

    assign reject = wr_cmd && busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            busy_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (wr_cmd && !busy_q) begin
                cmd_q   <= wdata;
                busy_q  <= 1'b1;
                start_q <= 1'b1;
            end else if (done) begin
                busy_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/twi_ctrl_regs.sv
module twi_ctrl_regs
    import twi_regs_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int CMD_W   = 10,
    parameter int TADDR_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_en,
    input  logic               acc_we,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [31:0]        acc_wdata,
    output logic [31:0]        acc_rdata,
    input  logic               ev_done,
    input  logic               ev_lost_arb,
    input  logic               ev_no_resp,
    input  logic               ev_collision,
    input  logic               ev_bus_busy,
    input  logic               rx_load,
    input  logic [63:0]        rx_data,
    output logic               cmd_start,
    output logic [CMD_W-1:0]   cmd_word,
    output logic [TADDR_W-1:0] tgt_addr,
    output logic [63:0]        tx_data,
    output logic [31:0]        clk_std_word,
    output logic [31:0]        clk_hs_word,
    output logic [31:0]        cfg_word,
    output logic               irq
);

    reg_sel_e           sel;
    logic               wr;
    logic               wr_cmd;
    logic               cmd_busy;
    logic               cmd_reject;
    logic [NUM_EV-1:0]  ev_vec;
    logic [NUM_EV-1:0]  sts_vec;
    logic [NUM_EV-1:0]  msk_vec;
    clk_cfg_t           clk_std_q;
    clk_cfg_t           clk_hs_q;
    ctl_cfg_t           ctl_q;
    logic [31:0]        dat0_q;
    logic [31:0]        dat1_q;

    assign sel    = decode_sel(32'(acc_addr));
    assign wr     = acc_en && acc_we;
    assign wr_cmd = wr && (sel == SEL_CMD);

    always_comb begin
        ev_vec             = '0;
        ev_vec[EV_DONE]    = ev_done;
        ev_vec[EV_ARB]     = ev_lost_arb;
        ev_vec[EV_NORESP]  = ev_no_resp;
        ev_vec[EV_COLL]    = ev_collision;
        ev_vec[EV_BUSBUSY] = ev_bus_busy || cmd_reject;
    end

    twi_cfg_bank #(.TADDR_W(TADDR_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .we_std    (wr && sel == SEL_CLK_STD),
        .we_hs     (wr && sel == SEL_CLK_HS),
        .we_ctl    (wr && sel == SEL_CFG),
        .we_tgt    (wr && sel == SEL_TADDR),
        .we_d0     (wr && sel == SEL_DAT0),
        .we_d1     (wr && sel == SEL_DAT1),
        .wdata     (acc_wdata),
        .rx_load   (rx_load),
        .rx_data   (rx_data),
        .clk_std_q (clk_std_q),
        .clk_hs_q  (clk_hs_q),
        .ctl_q     (ctl_q),
        .tgt_q     (tgt_addr),
        .dat0_q    (dat0_q),
        .dat1_q    (dat1_q)
    );

    twi_irq_block #(.NEV(NUM_EV)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .ev_set (ev_vec),
        .sts_wr (wr && sel == SEL_STS),
        .msk_wr (wr && sel == SEL_MSK),
        .wbits  (acc_wdata[NUM_EV-1:0]),
        .sts_q  (sts_vec),
        .msk_q  (msk_vec),
        .irq    (irq)
    );

    twi_cmd_launch #(.CMD_W(CMD_W)) u_launch (
        .clk     (clk),
        .rst     (rst),
        .wr_cmd  (wr_cmd),
        .wdata   (acc_wdata[CMD_W-1:0]),
        .done    (ev_done),
        .cmd_q   (cmd_word),
        .busy_q  (cmd_busy),
        .start_q (cmd_start),
        .reject  (cmd_reject)
    );

    assign clk_std_word = clk_image(clk_std_q);
    assign clk_hs_word  = clk_image(clk_hs_q);
    assign cfg_word     = ctl_image(ctl_q);
    assign tx_data      = {dat1_q, dat0_q};

    always_comb begin
        acc_rdata = '0;
        if (acc_en && !acc_we) begin
            case (sel)
                SEL_CLK_STD: acc_rdata = clk_std_word;
                SEL_CLK_HS:  acc_rdata = clk_hs_word;
                SEL_CFG:     acc_rdata = cfg_word;
                SEL_CMD:     acc_rdata = 32'(cmd_word);
                SEL_TADDR:   acc_rdata = 32'(tgt_addr);
                SEL_DAT0:    acc_rdata = dat0_q;
                SEL_DAT1:    acc_rdata = dat1_q;
                SEL_STS:     acc_rdata = 32'(sts_vec);
                SEL_MSK:     acc_rdata = 32'(msk_vec);
                SEL_BUSY:    acc_rdata = {31'h0, cmd_busy};
                default:     acc_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/twi_ctrl_regs_chk.sv
module twi_ctrl_regs_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_cmd,
    input logic       busy,
    input logic       cmd_start,
    input logic       clr_b0,
    input logic       ev_done,
    input logic [4:0] sts
);

    // R5: a launch pulse only follows an accepted command write
    a_r5_start_after_write: assert property (@(posedge clk) disable iff (rst)
        cmd_start |-> $past(wr_cmd && !busy));

    // R5: the launch pulse coincides with the busy flag being raised
    a_r5_busy_with_start: assert property (@(posedge clk) disable iff (rst)
        cmd_start |-> busy);

    // R6: a command written while busy gives no launch and flags bus busy
    a_r6_reject_while_busy: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && busy) |=> (!cmd_start && sts[4]));

    // R7: a write-one clear with no competing event drops the done flag
    a_r7_clear_done: assert property (@(posedge clk) disable iff (rst)
        (clr_b0 && !ev_done) |=> !sts[0]);

    // R8: a done pulse always leaves the flag set, clear or not
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        ev_done |=> sts[0]);

endmodule

bind twi_ctrl_regs twi_ctrl_regs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_cmd    (wr_cmd),
    .busy      (cmd_busy),
    .cmd_start (cmd_start),
    .clr_b0    (wr && (sel == twi_regs_pkg::SEL_STS) && acc_wdata[0]),
    .ev_done   (ev_done),
    .sts       (sts_vec)
);

// File: tb/twi_ctrl_regs_bench.sv
`timescale 1ns/1ps
module twi_ctrl_regs_bench;

    localparam int ADDR_W  = 8;
    localparam int CMD_W   = 10;
    localparam int TADDR_W = 10;

    logic               clk = 1'b0;
    logic               rst;
    logic               acc_en, acc_we;
    logic [ADDR_W-1:0]  acc_addr;
    logic [31:0]        acc_wdata, acc_rdata;
    logic               ev_done, ev_lost_arb, ev_no_resp, ev_collision, ev_bus_busy;
    logic               rx_load;
    logic [63:0]        rx_data;
    logic               cmd_start;
    logic [CMD_W-1:0]   cmd_word;
    logic [TADDR_W-1:0] tgt_addr;
    logic [63:0]        tx_data;
    logic [31:0]        clk_std_word, clk_hs_word, cfg_word;
    logic               irq;

    int checks = 0;
    int fails  = 0;

    logic [31:0] q_exp[$];
    string       q_tag[$];

    always #4 clk = ~clk;

    twi_ctrl_regs #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .TADDR_W(TADDR_W)) u_twi_ctrl_regs (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .ev_done(ev_done),
        .ev_lost_arb(ev_lost_arb), .ev_no_resp(ev_no_resp), .ev_collision(ev_collision),
        .ev_bus_busy(ev_bus_busy), .rx_load(rx_load), .rx_data(rx_data),
        .cmd_start(cmd_start), .cmd_word(cmd_word), .tgt_addr(tgt_addr), .tx_data(tx_data),
        .clk_std_word(clk_std_word), .clk_hs_word(clk_hs_word), .cfg_word(cfg_word), .irq(irq)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Drive one cycle of stimulus starting at a falling edge.
    task automatic cyc(input logic en, input logic we, input logic [7:0] a,
                       input logic [31:0] d, input logic [4:0] ev);
        @(negedge clk);
        acc_en = en; acc_we = we; acc_addr = a; acc_wdata = d;
        ev_done = ev[0]; ev_lost_arb = ev[1]; ev_no_resp = ev[2];
        ev_collision = ev[3]; ev_bus_busy = ev[4];
        rx_load = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(1'b1, 1'b1, a, d, 5'h0);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        q_exp.push_back(exp);
        q_tag.push_back(tag);
        cyc(1'b1, 1'b0, a, 32'h0, 5'h0);
    endtask

    task automatic ev(input logic [4:0] e);
        cyc(1'b0, 1'b0, 8'h0, 32'h0, e);
    endtask

    // Idle one cycle and leave the caller 2 ns after the falling edge.
    task automatic look();
        cyc(1'b0, 1'b0, 8'h0, 32'h0, 5'h0);
        #2;
    endtask

    // Monitor: compare every read against the scoreboard queue.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (acc_en && !acc_we) begin
                if (q_exp.size() == 0) begin
                    check("scoreboard underflow", 64'h1, 64'h0);
                end else begin
                    check(q_tag.pop_front(), 64'(acc_rdata), 64'(q_exp.pop_front()));
                end
            end
        end
    end

    initial begin
        #(8 * 50000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; acc_en = 0; acc_we = 0; acc_addr = '0; acc_wdata = '0;
        ev_done = 0; ev_lost_arb = 0; ev_no_resp = 0; ev_collision = 0; ev_bus_busy = 0;
        rx_load = 0; rx_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd(8'h00, 32'h0000301F, "R1 clk std reset");
        rd(8'h04, 32'h0000301F, "R1 clk hs reset");
        rd(8'h08, 32'h00003302, "R1 cfg reset");
        rd(8'h1C, 32'h0, "R1 status reset");
        rd(8'h20, 32'h0, "R1 mask reset");
        rd(8'h24, 32'h0, "R1 busy reset");
        look(); check("R1 irq reset", 64'(irq), 64'h0);

        // R2 clock field packing
        wr(8'h00, 32'hFFFFFFFF);
        rd(8'h00, 32'h0000F3FF, "R2 clk std all ones");
        wr(8'h04, 32'h12345678);
        rd(8'h04, 32'h00005278, "R2 clk hs pattern");
        look(); check("R2 clk_hs_word", 64'(clk_hs_word), 64'h5278);

        // R3 config field packing
        wr(8'h08, 32'hFFFFFFFF);
        rd(8'h08, 32'h0000FFF3, "R3 cfg all ones");
        wr(8'h08, 32'h0);
        rd(8'h08, 32'h0, "R3 cfg zero");

        // R4 address and data
        wr(8'h10, 32'hFFFFFFFF);
        rd(8'h10, 32'h000003FF, "R4 target address");
        wr(8'h14, 32'hDEADBEEF);
        wr(8'h18, 32'h01234567);
        look(); check("R4 tx_data", tx_data, 64'h01234567_DEADBEEF);
        @(negedge clk);
        acc_en = 0; acc_we = 0; rx_load = 1'b1; rx_data = 64'hA5A5A5A5_5A5A5A5A;
        rd(8'h14, 32'h5A5A5A5A, "R4 rx load data0");
        rd(8'h18, 32'hA5A5A5A5, "R4 rx load data1");

        // R5 launch
        wr(8'h0C, 32'hFFFFF273);
        look(); check("R5 start pulse", 64'(cmd_start), 64'h1);
        check("R5 cmd_word", 64'(cmd_word), 64'h273);
        look(); check("R5 start one cycle", 64'(cmd_start), 64'h0);
        rd(8'h24, 32'h1, "R5 busy while running");

        // R6 command while busy
        wr(8'h0C, 32'h111);
        look(); check("R6 no start when busy", 64'(cmd_start), 64'h0);
        check("R6 cmd_word kept", 64'(cmd_word), 64'h273);
        rd(8'h1C, 32'h10, "R6 bus busy flag");
        wr(8'h1C, 32'h10);

        // R7 / R9 done with error captured together, only done unmasked
        ev(5'b00101);
        rd(8'h24, 32'h0, "R5 busy cleared by done");
        rd(8'h1C, 32'h05, "R7 done and no-response set");
        look(); check("R9 irq masked off", 64'(irq), 64'h0);
        wr(8'h20, 32'h00000001);
        look(); check("R9 irq via done", 64'(irq), 64'h1);
        wr(8'h1C, 32'h00000002);
        rd(8'h1C, 32'h05, "R7 writing other bits keeps flags");
        wr(8'h1C, 32'h00000005);
        rd(8'h1C, 32'h0, "R7 write-one clears");
        look(); check("R9 irq drops after clear", 64'(irq), 64'h0);
        wr(8'h20, 32'hFFFFFFFF);
        rd(8'h20, 32'h1F, "R9 mask width");

        // R8 set beats clear
        ev(5'b00010);
        look(); check("R9 irq from lost arbitration", 64'(irq), 64'h1);
        cyc(1'b1, 1'b1, 8'h1C, 32'h2, 5'b00010);
        rd(8'h1C, 32'h02, "R8 set wins over clear");
        wr(8'h1C, 32'h2);
        rd(8'h1C, 32'h0, "R8 later clear works");
        wr(8'h20, 32'h0);

        // R10 unmapped offsets
        rd(8'h28, 32'h0, "R10 read beyond map");
        rd(8'h01, 32'h0, "R10 unaligned read");
        wr(8'h28, 32'hFFFFFFFF);
        wr(8'h02, 32'hFFFFFFFF);
        rd(8'h00, 32'h0000F3FF, "R10 clk std untouched");
        rd(8'h08, 32'h0, "R10 cfg untouched");
        rd(8'h20, 32'h0, "R10 mask untouched");
        look(); check("R10 no launch", 64'(cmd_start), 64'h0);

        look();
        if (q_exp.size() != 0) check("scoreboard drained", 64'(q_exp.size()), 64'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule